// File: doc/BRIEF.md
# PWM Fault Override Controller

This block sits between a four-channel complementary PWM generator and the output pins. When an external fault pin asserts, it forces every enabled output pair to a per-pin programmed level. The high pin and the low pin of each pair each have their own override bit. Disabled pairs are not affected and keep following the generator.

A 16-bit control register sets the override levels, the pair enables and the recovery mode. Software writes and reads it over a simple register bus. In cycle-by-cycle recovery, normal output comes back at the first period boundary after the fault clears. In latched recovery, a sticky flag holds the override until software clears it, and output is released at the following period boundary.

The fault pin is asynchronous. It passes through a two-stage synchronizer before it is used. A status output reports whether an enabled pair is being overridden at present.

Top module: `pwm_fault_ovr`

## Requirements
- R1: After synchronous active-low reset, the control register reads 0x0000, every pin output equals its PWM input, and `fault_active_o` is 0.
- R2: A register write stores `reg_wdata_i` on the clock edge. `reg_rdata_o` returns the stored word from the next cycle. Bits 6..4 are never stored and always read as 0.
- R3: The register fields are as follows:
  - Pair p (p = 0..3) has its high-pin override at bit 9+2p and its low-pin override at bit 8+2p.
  - The enable for pair p is at bit p.
  - Bit 7 is the recovery mode: 1 selects cycle-by-cycle and 0 selects latched.
  - While the override is in force, each pin of an enabled pair drives exactly its override bit. A value of 1 is the active level and 0 is the inactive level.
- R4: `fault_pin_i` passes through two synchronizer flops. The override register sets on the edge after that. A fault driven high just after a rising edge therefore changes the pins after the third rising edge, and not after the second.
- R5: A pair whose enable bit is 0 passes its PWM inputs to its pins at all times, whatever the fault state.
- R6: In cycle-by-cycle mode, the override holds while the synchronized fault is high, even across period-start strobes. It releases on the first edge where `period_start_i` is high and the synchronized fault is low.
- R7: In latched mode, a fault sets a sticky flag. While the flag is set, period-start strobes do not release the override, even after the fault has gone away.
- R8: A pulse on `fault_clr_i` clears the sticky flag only when the synchronized fault is low. A pulse while the synchronized fault is high is ignored.
- R9: Once the sticky flag is cleared and the fault is low, the override releases at the next period-start strobe.
- R10: `fault_active_o` is 1 exactly when the override is in force and at least one pair enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_hi_i | input | 4 | Raw high-side PWM signals, one bit per pair |
| pwm_lo_i | input | 4 | Raw low-side PWM signals, one bit per pair |
| period_start_i | input | 1 | One-cycle strobe at each PWM period start |
| fault_pin_i | input | 1 | Asynchronous external fault input, active high |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 16 | Control register write data |
| fault_clr_i | input | 1 | Software strobe that clears the latched fault flag |
| reg_rdata_o | output | 16 | Control register read value |
| pin_hi_o | output | 4 | Final high-side pin drives |
| pin_lo_o | output | 4 | Final low-side pin drives |
| fault_active_o | output | 1 | Override in force on at least one enabled pair |

## Verification
The bench first samples the pins after two rising edges and then after three, following a fault edge. A synchronizer that is one stage too short or too long therefore shows up as an early or a late override. It pulses period-start while the fault is still high, and in latched mode after the fault is gone. A design that released on any strobe would wrongly restore PWM output in either case. It also pulses the clear strobe while the fault is still present; a clear that ignores the fault level would let the next strobe release the pins too soon. Written values include set unused bits, which must read back as zero. One pair is left disabled throughout, which catches a mux that overrides every pair.

// File: rtl/pfo_pkg.sv
// Package: shared field positions and types of the fault override controller.
// Assumes the fixed 16-bit control word with four complementary pairs.
package pfo_pkg;
    localparam int NUM_PAIRS = 4;
    localparam int CTRL_W    = 16;
    localparam int EN_BASE   = 0;
    localparam int MODE_BIT  = 7;
    localparam int OVR_BASE  = 8;
    localparam int GAP_LO    = 4;
    localparam int GAP_HI    = 6;

    typedef enum logic {
        REC_LATCHED = 1'b0,
        REC_CYCLE   = 1'b1
    } rec_mode_e;

    // Bit index of the high-pin override of pair p.
    function automatic int ovr_hi_bit(input int p);
        return OVR_BASE + 2 * p + 1;
    endfunction

    // Bit index of the low-pin override of pair p.
    function automatic int ovr_lo_bit(input int p);
        return OVR_BASE + 2 * p;
    endfunction

    // Mask of the bits that are actually stored.
    function automatic logic [CTRL_W-1:0] store_mask();
        logic [CTRL_W-1:0] m;
        m = '1;
        for (int b = GAP_LO; b <= GAP_HI; b++) m[b] = 1'b0;
        return m;
    endfunction
endpackage

// File: rtl/pfo_sync.sv
// Module: multi-stage synchronizer for the asynchronous fault pin.
// Assumes the pin is level-based and stays high for at least STAGES+1 cycles.
module pfo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one flop of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= 1'b0;
                else        chain_q[s] <= (s == 0) ? async_i : chain_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfo_ctrl_reg.sv
// Module: 16-bit control register of the fault override controller.
// Assumes a single-cycle write strobe; reads are combinational from storage.
module pfo_ctrl_reg
    import pfo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic [CTRL_W-1:0] ctrl_o
);
    localparam logic [CTRL_W-1:0] MASK = store_mask();

    logic [CTRL_W-1:0] ctrl_q;

    // Purpose: store written value with the unused gap forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)    ctrl_q <= '0;
        else if (we_i) ctrl_q <= wdata_i & MASK;
    end

    assign ctrl_o = ctrl_q;

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (ctrl_o == ($past(wdata_i) & MASK)));

    p_idle_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(ctrl_o));
endmodule

// File: rtl/pfo_recovery.sv
// Module: override engage/release control with latched and per-cycle modes.
// Assumes fault_sync_i is already synchronous and period_start_i is one cycle wide.
module pfo_recovery
    import pfo_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fault_sync_i,
    input  rec_mode_e mode_i,
    input  logic      clr_i,
    input  logic      period_start_i,
    output logic      override_o,
    output logic      sticky_o
);
    logic ovr_q;
    logic sticky_q;
    logic clear_ok;

    assign clear_ok = clr_i && !fault_sync_i;

    // Purpose: sticky fault flag, set by a fault in latched mode, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     sticky_q <= 1'b0;
        else if (fault_sync_i && mode_i == REC_LATCHED) sticky_q <= 1'b1;
        else if (clear_ok)                              sticky_q <= 1'b0;
    end

    // Purpose: override in force; engages at once, releases only on a period start.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   ovr_q <= 1'b0;
        else if (fault_sync_i)                        ovr_q <= 1'b1;
        else if (ovr_q && period_start_i && !sticky_q) ovr_q <= 1'b0;
    end

    assign override_o = ovr_q;
    assign sticky_o   = sticky_q;

    p_engage_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_sync_i |=> override_o);

    p_hold_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        override_o && !period_start_i |=> override_o);

    p_latched_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_o |=> override_o);

    p_clear_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_o && fault_sync_i |=> sticky_o);

    p_release_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(override_o) |-> $past(period_start_i));
endmodule

// File: rtl/pwm_fault_ovr.sv
// Module: top of the PWM fault override controller.
// Forces enabled complementary pairs to programmed pin levels during a fault.
// Assumes PWM inputs are synchronous to clk; the fault pin may be asynchronous.
module pwm_fault_ovr
    import pfo_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PAIRS-1:0] pwm_hi_i,
    input  logic [NUM_PAIRS-1:0] pwm_lo_i,
    input  logic                 period_start_i,
    input  logic                 fault_pin_i,
    input  logic                 reg_we_i,
    input  logic [CTRL_W-1:0]    reg_wdata_i,
    input  logic                 fault_clr_i,
    output logic [CTRL_W-1:0]    reg_rdata_o,
    output logic [NUM_PAIRS-1:0] pin_hi_o,
    output logic [NUM_PAIRS-1:0] pin_lo_o,
    output logic                 fault_active_o
);
    logic [CTRL_W-1:0]    ctrl;
    logic                 fault_sync;
    logic                 override;
    logic                 sticky;
    logic [NUM_PAIRS-1:0] pair_en;
    rec_mode_e            mode;

    pfo_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (fault_pin_i),
        .sync_o  (fault_sync)
    );

    pfo_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we_i),
        .wdata_i (reg_wdata_i),
        .ctrl_o  (ctrl)
    );

    assign mode    = rec_mode_e'(ctrl[MODE_BIT]);
    assign pair_en = ctrl[EN_BASE +: NUM_PAIRS];

    pfo_recovery u_rec (
        .clk            (clk),
        .rst_n          (rst_n),
        .fault_sync_i   (fault_sync),
        .mode_i         (mode),
        .clr_i          (fault_clr_i),
        .period_start_i (period_start_i),
        .override_o     (override),
        .sticky_o       (sticky)
    );

    generate
        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
            logic forced;
            // Purpose: select override level or raw PWM for this pair.
            always_comb begin
                forced      = override && pair_en[p];
                pin_hi_o[p] = forced ? ctrl[ovr_hi_bit(p)] : pwm_hi_i[p];
                pin_lo_o[p] = forced ? ctrl[ovr_lo_bit(p)] : pwm_lo_i[p];
            end
        end
    endgenerate

    assign fault_active_o = override && (|pair_en);
    assign reg_rdata_o    = ctrl;

    p_status_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_active_o |-> (reg_rdata_o[NUM_PAIRS-1:0] != '0));

    p_gap_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_we_i) |-> (reg_rdata_o[GAP_HI:GAP_LO] == '0));

    p_sticky_in_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_sync && mode == REC_LATCHED |=> sticky);
endmodule

// File: tb/test_pwm_fault_ovr.sv
module test_pwm_fault_ovr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pwm_hi = 4'h0;
    logic [3:0]  pwm_lo = 4'h0;
    logic        period_start = 1'b0;
    logic        fault_pin = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic        fault_clr = 1'b0;
    logic [15:0] reg_rdata;
    logic [3:0]  pin_hi;
    logic [3:0]  pin_lo;
    logic        fault_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pwm_fault_ovr i_pwm_fault_ovr (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwm_hi_i       (pwm_hi),
        .pwm_lo_i       (pwm_lo),
        .period_start_i (period_start),
        .fault_pin_i    (fault_pin),
        .reg_we_i       (reg_we),
        .reg_wdata_i    (reg_wdata),
        .fault_clr_i    (fault_clr),
        .reg_rdata_o    (reg_rdata),
        .pin_hi_o       (pin_hi),
        .pin_lo_o       (pin_lo),
        .fault_active_o (fault_active)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected pins from R3/R5: enabled pair under override takes its override bits.
    function automatic logic [3:0] exp_hi(input logic [15:0] c, input logic ovr, input logic [3:0] raw);
        logic [3:0] r;
        for (int p = 0; p < 4; p++) r[p] = (ovr && c[p]) ? c[9 + 2*p] : raw[p];
        return r;
    endfunction

    function automatic logic [3:0] exp_lo(input logic [15:0] c, input logic ovr, input logic [3:0] raw);
        logic [3:0] r;
        for (int p = 0; p < 4; p++) r[p] = (ovr && c[p]) ? c[8 + 2*p] : raw[p];
        return r;
    endfunction

    task automatic pins_chk(input string req, input logic [15:0] c, input logic ovr);
        chk(req, "pin_hi", {12'h0, pin_hi}, {12'h0, exp_hi(c, ovr, pwm_hi)});
        chk(req, "pin_lo", {12'h0, pin_lo}, {12'h0, exp_lo(c, ovr, pwm_lo)});
        chk(req, "fault_active", {15'h0, fault_active}, {15'h0, ovr && (c[3:0] != 4'h0)});
    endtask

    task automatic write_reg(input logic [15:0] v);
        @(negedge clk); reg_we = 1'b1; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic strobe_period();
        @(negedge clk); period_start = 1'b1;
        @(negedge clk); period_start = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); fault_clr = 1'b1;
        @(negedge clk); fault_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R1: reset state.
    task automatic t_reset();
        pwm_hi = 4'b1010; pwm_lo = 4'b0101;
        idle(1);
        chk("R1", "rdata after reset", reg_rdata, 16'h0000);
        pins_chk("R1", 16'h0000, 1'b0);
    endtask

    // R2: write/read with gap bits ignored.
    task automatic t_register();
        write_reg(16'hFFFF);
        chk("R2", "rdata all-ones write", reg_rdata, 16'hFF8F);
        write_reg(16'h0070);
        chk("R2", "rdata gap-only write", reg_rdata, 16'h0000);
    endtask

    // R3 R4 R5 R6 R10: cycle-by-cycle mode.
    task automatic t_cycle_mode();
        logic [15:0] c;
        c = 16'h9CFB;  // pairs 4..1 ovr 10,01,11,00; cycle mode; pair 3 disabled
        write_reg(c);
        c = 16'h9C8B;
        chk("R2", "rdata config", reg_rdata, c);
        pwm_hi = 4'b0101; pwm_lo = 4'b1010;
        @(negedge clk); fault_pin = 1'b1;
        idle(2);
        pins_chk("R4", c, 1'b0);          // not yet after two edges
        idle(1);
        pins_chk("R4", c, 1'b1);          // override after third edge
        pwm_hi = 4'b1111; pwm_lo = 4'b0000;
        idle(1);
        pins_chk("R3", c, 1'b1);          // overridden pins ignore PWM; pair 3 follows (R5)
        chk("R5", "disabled pair hi", {15'h0, pin_hi[2]}, 16'h0001);
        strobe_period();                  // fault still high: no release
        pins_chk("R6", c, 1'b1);
        fault_pin = 1'b0;
        idle(5);
        pins_chk("R6", c, 1'b1);          // held until period start
        strobe_period();
        pins_chk("R6", c, 1'b0);
        chk("R10", "status after release", {15'h0, fault_active}, 16'h0000);
    endtask

    // R10: no enables means no status even under fault; R5 all disabled.
    task automatic t_no_enables();
        logic [15:0] c;
        c = 16'hFF80;
        write_reg(c);
        pwm_hi = 4'b0011; pwm_lo = 4'b1100;
        @(negedge clk); fault_pin = 1'b1;
        idle(4);
        pins_chk("R5", c, 1'b0);
        chk("R10", "status without enables", {15'h0, fault_active}, 16'h0000);
        fault_pin = 1'b0;
        idle(3);
        strobe_period();
    endtask

    // R7 R8 R9: latched mode.
    task automatic t_latched();
        logic [15:0] c;
        c = 16'h660F;  // pairs 4..1 ovr 01,10,01,10; latched; all enabled
        write_reg(c);
        pwm_hi = 4'b1001; pwm_lo = 4'b0110;
        @(negedge clk); fault_pin = 1'b1;
        idle(3);
        pins_chk("R7", c, 1'b1);
        pulse_clear();                    // ignored while fault high
        fault_pin = 1'b0;
        idle(3);
        strobe_period();
        pins_chk("R8", c, 1'b1);
        strobe_period();
        pins_chk("R7", c, 1'b1);
        pulse_clear();                    // fault low now: accepted
        pins_chk("R9", c, 1'b1);          // still held until strobe
        idle(2);
        pins_chk("R9", c, 1'b1);
        strobe_period();
        pins_chk("R9", c, 1'b0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_register();
        t_cycle_mode();
        t_no_enables();
        t_latched();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule